// File: doc/BRIEF.md
# Single-Line Request/Grant Bus Arbiter

This block sits on the bus-owning side of a mastership handshake. Each handshake channel uses one shared, active-low line that idles high. An outside master asks for the local bus with a one-clock low pulse. The block answers on the same line with a one-clock low grant pulse. The outside master ends its tenure with a second one-clock low pulse. Two channels are served, and the lower-numbered channel wins when both are waiting.

The block follows the phase of the processor's bus cycle (idle, T1 to T4) together with three qualifier flags: an odd-address low-byte access, the first acknowledge of an interrupt-acknowledge pair, and a running locked instruction. It grants only in an idle clock or in the T4 clock of a cycle that passes every qualifier. The clock after the grant it raises a hold-acknowledge output and takes away the output enables of the bus status and lock outputs. It reclaims the bus the clock after the release pulse, and it keeps one dead clock before another exchange can begin.

Each line is modelled as a separate input, output and output-enable. The block only observes a line while it is not driving that line itself.

Top module: `rqgt_arbiter`

## Requirements
- R1: After synchronous active-high reset, no request is pending, every line output-enable is low, holdAck is low, and the status and lock output enables are high.
- R2: In the owning state, a low pulse on a line sampled in an idle clock (busPhase 0) produces a grant in the next clock if that clock is also idle and lockActive is low. During the grant, rqOe is high and rqOut is low on that line only, for exactly one clock.
- R3: From the clock after a grant until the clock in which the release pulse is on the line, inclusive, holdAck is high and statusOe and lockOe are low.
- R4: The block's own grant pulse is never taken as the release. holdAck stays high after the grant clock while the master leaves the line high.
- R5: The clock after a release pulse is a dead clock. holdAck is low, no grant is driven, and a low level on any line during that clock is ignored.
- R6: The busPhase encoding is idle=0, T1=1, T2=2, T3=3, T4=4. A request sampled in T1 or T2 of a memory cycle is granted in the T4 clock of that same cycle when no blocking flag is set.
- R7: A request first seen in T3 is not granted in that cycle's T4. It is granted in the T4 of the following cycle.
- R8: A T4 grant is withheld while oddLowByte, intaFirst or lockActive is high. An idle-clock grant is withheld while lockActive is high. A withheld request stays pending and is granted at the next qualifying T4 or idle clock.
- R9: When both channels are pending and eligible, channel 0 is granted first. Channel 1 stays pending through channel 0's exchange and is granted after the dead clock.
- R10: A request seen in a T4 clock counts as early for the next cycle and is granted in that cycle's T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busPhase | input | 3 | Bus cycle phase: 0 idle, 1..4 = T1..T4 |
| oddLowByte | input | 1 | Current cycle is the low byte of an odd-address word |
| intaFirst | input | 1 | Current cycle is the first interrupt acknowledge |
| lockActive | input | 1 | A locked instruction is running |
| rqIn | input | NCH | Sensed level of each request/grant line |
| rqOut | output | NCH | Level driven onto each line when enabled |
| rqOe | output | NCH | Output enable of each line (grant pulse) |
| statusIn | input | STW | Bus status from the cycle generator |
| statusOut | output | STW | Bus status to the pins |
| statusOe | output | 1 | Output enable of the bus status pins |
| lockNIn | input | 1 | Active-low lock from the core |
| lockNOut | output | 1 | Active-low lock to the pin |
| lockOe | output | 1 | Output enable of the lock pin |
| holdAck | output | 1 | Hold-acknowledge: bus floated and handed over |

## Verification
The bench builds the block with its defaults, NCH=2 and STW=3. Two channels are the smallest setup in which both lines pulse low in the same clock, so priority and a pending channel 1 that outlives channel 0's whole exchange can be observed at the pins. The shared lines are modelled as resolved wires, so the block's own grant pulse reaches its input exactly as it would on a board. Walks through T1 to T4 place requests in each phase against each blocking flag.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } busPhase_e;

  typedef enum logic [1:0] {
    ST_OWN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_DEAD = 2'd2
  } arbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic grantNow;  // grant pulse on the selected line this clock
    logic inHold;    // bus handed over
    logic sampleEn;  // lines observed this clock
  } arbStrobe_t;

endpackage

// File: rtl/rqgt_datapath.sv
module rqgt_datapath
  import rqgt_pkg::*;
#(
  parameter int NCH = 2,
  parameter int STW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       busPhase,
  input  logic             oddLowByte,
  input  logic             intaFirst,
  input  logic             lockActive,
  input  logic [NCH-1:0]   rqIn,
  output logic [NCH-1:0]   rqOut,
  output logic [NCH-1:0]   rqOe,
  input  logic [STW-1:0]   statusIn,
  output logic [STW-1:0]   statusOut,
  output logic             statusOe,
  input  logic             lockNIn,
  output logic             lockNOut,
  output logic             lockOe,
  input  arbStrobe_t       strobe,
  output logic             candValid,
  output logic             releaseSeen
);

  busPhase_e ph;
  logic [NCH-1:0] pending, early, ownerOH;
  logic [NCH-1:0] lineLow, capture, eligMask, candOH;
  logic found, windowOk;

  assign ph = busPhase_e'(busPhase);

  // a line counts as low only while this block is not driving it
  assign lineLow = ~rqIn & ~rqOe;
  assign capture = lineLow & ~pending & {NCH{strobe.sampleEn}}
                 & ~(ownerOH & {NCH{strobe.inHold}});

  assign eligMask = pending & early;

  // lowest index wins
  always_comb begin
    candOH = '0;
    found  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (eligMask[i] && !found) begin
        candOH[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign windowOk  = !lockActive &&
                     (ph == PH_IDLE || (ph == PH_T4 && !oddLowByte && !intaFirst));
  assign candValid = found && windowOk;

  assign rqOe  = candOH & {NCH{strobe.grantNow}};
  assign rqOut = ~rqOe;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      always_ff @(posedge clk) begin
        if (rst) begin
          pending[g] <= 1'b0;
          early[g]   <= 1'b0;
        end else if (strobe.grantNow && candOH[g]) begin
          pending[g] <= 1'b0;
          early[g]   <= 1'b0;
        end else if (capture[g]) begin
          pending[g] <= 1'b1;
          early[g]   <= (ph != PH_T3);  // seen in T3: too late for this T4
        end else if (pending[g] && (ph == PH_T4 || ph == PH_IDLE)) begin
          early[g]   <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                  ownerOH <= '0;
    else if (strobe.grantNow) ownerOH <= candOH;
  end

  assign releaseSeen = strobe.inHold && |(lineLow & ownerOH);

  assign statusOut = statusIn;
  assign statusOe  = ~strobe.inHold;
  assign lockNOut  = lockNIn;
  assign lockOe    = ~strobe.inHold;

endmodule

// File: rtl/rqgt_control.sv
module rqgt_control
  import rqgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       candValid,
  input  logic       releaseSeen,
  output arbStrobe_t strobe,
  output logic       holdAck
);

  arbState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_OWN:  if (candValid)   stateNxt = ST_HOLD;
      ST_HOLD: if (releaseSeen) stateNxt = ST_DEAD;
      ST_DEAD:                  stateNxt = ST_OWN;
      default:                  stateNxt = ST_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OWN;
    else     state <= stateNxt;
  end

  assign strobe.grantNow = (state == ST_OWN) && candValid;
  assign strobe.inHold   = (state == ST_HOLD);
  assign strobe.sampleEn = (state != ST_DEAD);
  assign holdAck         = (state == ST_HOLD);

endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
  import rqgt_pkg::*;
#(
  parameter int NCH = 2,
  parameter int STW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     busPhase,
  input  logic           oddLowByte,
  input  logic           intaFirst,
  input  logic           lockActive,
  input  logic [NCH-1:0] rqIn,
  output logic [NCH-1:0] rqOut,
  output logic [NCH-1:0] rqOe,
  input  logic [STW-1:0] statusIn,
  output logic [STW-1:0] statusOut,
  output logic           statusOe,
  input  logic           lockNIn,
  output logic           lockNOut,
  output logic           lockOe,
  output logic           holdAck
);

  arbStrobe_t strobe;
  logic candValid, releaseSeen;

  rqgt_datapath #(.NCH(NCH), .STW(STW)) u_dp (
    .clk(clk), .rst(rst), .busPhase(busPhase), .oddLowByte(oddLowByte),
    .intaFirst(intaFirst), .lockActive(lockActive), .rqIn(rqIn),
    .rqOut(rqOut), .rqOe(rqOe), .statusIn(statusIn), .statusOut(statusOut),
    .statusOe(statusOe), .lockNIn(lockNIn), .lockNOut(lockNOut),
    .lockOe(lockOe), .strobe(strobe), .candValid(candValid),
    .releaseSeen(releaseSeen)
  );

  rqgt_control u_ctl (
    .clk(clk), .rst(rst), .candValid(candValid), .releaseSeen(releaseSeen),
    .strobe(strobe), .holdAck(holdAck)
  );

endmodule

// File: rtl/rqgt_arbiter_checker.sv
module rqgt_arbiter_checker #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     busPhase,
  input logic           lockActive,
  input logic [NCH-1:0] rqOe,
  input logic           holdAck,
  input logic           statusOe,
  input logic           lockOe
);

  a_r2_grant_one_clock: assert property (@(posedge clk) disable iff (rst)
    (rqOe != '0) |=> (rqOe == '0));

  a_r2_grant_window: assert property (@(posedge clk) disable iff (rst)
    (rqOe != '0) |-> (busPhase == 3'd0 || busPhase == 3'd4));

  a_r3_hold_follows_grant: assert property (@(posedge clk) disable iff (rst)
    (rqOe != '0) |=> holdAck);

  a_r3_pins_float: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> (!statusOe && !lockOe));

  a_r3_no_grant_in_hold: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> (rqOe == '0));

  a_r5_dead_clock: assert property (@(posedge clk) disable iff (rst)
    $fell(holdAck) |-> (rqOe == '0));

  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (rst)
    lockActive |-> (rqOe == '0));

  a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rqOe));

endmodule

bind rqgt_arbiter rqgt_arbiter_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .busPhase(busPhase), .lockActive(lockActive),
  .rqOe(rqOe), .holdAck(holdAck), .statusOe(statusOe), .lockOe(lockOe)
);

// File: tb/rqgt_arbiter_bench.sv
`timescale 1ns/1ps
module rqgt_arbiter_bench;

  localparam int NCH = 2;
  localparam int STW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] busPhase = 3'd0;
  logic oddLowByte = 1'b0, intaFirst = 1'b0, lockActive = 1'b0;
  logic [NCH-1:0] md = '1;  // outside masters' drive, 1 = released
  logic [NCH-1:0] rqIn, rqOut, rqOe;
  logic [STW-1:0] statusIn = 3'b101, statusOut;
  logic statusOe, lockNIn = 1'b1, lockNOut, lockOe, holdAck;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [NCH-1:0] qOe[$];
  logic           qHold[$];
  string          qTag[$];

  always #4 clk = ~clk;  // 125 MHz

  for (genvar i = 0; i < NCH; i++) begin : g_line
    assign rqIn[i] = rqOe[i] ? rqOut[i] : md[i];
  end

  rqgt_arbiter #(.NCH(NCH), .STW(STW)) u_rqgt_arbiter (
    .clk(clk), .rst(rst), .busPhase(busPhase), .oddLowByte(oddLowByte),
    .intaFirst(intaFirst), .lockActive(lockActive), .rqIn(rqIn),
    .rqOut(rqOut), .rqOe(rqOe), .statusIn(statusIn), .statusOut(statusOut),
    .statusOe(statusOe), .lockNIn(lockNIn), .lockNOut(lockNOut),
    .lockOe(lockOe), .holdAck(holdAck)
  );

  // driver: one bus clock of stimulus plus the expected pin state
  task automatic cyc(input logic [2:0] ph, input logic [1:0] m,
                     input logic odd, input logic inta, input logic lk,
                     input logic [1:0] eOe, input logic eHold, input string tag);
    @(negedge clk);
    busPhase = ph; md = m; oddLowByte = odd; intaFirst = inta; lockActive = lk;
    qOe.push_back(eOe); qHold.push_back(eHold); qTag.push_back(tag);
  endtask

  // monitor: compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (qOe.size() > 0) begin
        logic [1:0] eOe;
        logic eH;
        string t;
        eOe = qOe.pop_front(); eH = qHold.pop_front(); t = qTag.pop_front();
        checks++;
        if (rqOe !== eOe || holdAck !== eH || statusOe !== ~eH || lockOe !== ~eH
            || ((rqOut & rqOe) !== '0)) begin
          fails++;
          $display("FAIL %s: rqOe=%b holdAck=%b statusOe=%b lockOe=%b expected rqOe=%b holdAck=%b",
                   t, rqOe, holdAck, statusOe, lockOe, eOe, eH);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R1");
    // R2 idle request, R3/R4 hold, R5 dead clock ignores a pulse
    cyc(0, 2'b10, 0, 0, 0, 2'b00, 0, "R2");
    cyc(0, 2'b11, 0, 0, 0, 2'b01, 0, "R2");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 1, "R4");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b10, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b10, 0, 0, 0, 2'b00, 0, "R5");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    // R6 request in T2 granted in same T4
    cyc(1, 2'b11, 0, 0, 0, 2'b00, 0, "R6");
    cyc(2, 2'b01, 0, 0, 0, 2'b00, 0, "R6");
    cyc(3, 2'b11, 0, 0, 0, 2'b00, 0, "R6");
    cyc(4, 2'b11, 0, 0, 0, 2'b10, 0, "R6");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b01, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    // R7 request in T3 waits a cycle
    cyc(1, 2'b11, 0, 0, 0, 2'b00, 0, "R7");
    cyc(2, 2'b11, 0, 0, 0, 2'b00, 0, "R7");
    cyc(3, 2'b10, 0, 0, 0, 2'b00, 0, "R7");
    cyc(4, 2'b11, 0, 0, 0, 2'b00, 0, "R7");
    cyc(1, 2'b11, 0, 0, 0, 2'b00, 0, "R7");
    cyc(2, 2'b11, 0, 0, 0, 2'b00, 0, "R7");
    cyc(3, 2'b11, 0, 0, 0, 2'b00, 0, "R7");
    cyc(4, 2'b11, 0, 0, 0, 2'b01, 0, "R7");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b10, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    // R8 blocking flags
    cyc(1, 2'b10, 0, 0, 0, 2'b00, 0, "R8");
    cyc(2, 2'b11, 0, 0, 0, 2'b00, 0, "R8");
    cyc(3, 2'b11, 0, 0, 0, 2'b00, 0, "R8");
    cyc(4, 2'b11, 1, 0, 0, 2'b00, 0, "R8");
    cyc(1, 2'b11, 0, 0, 0, 2'b00, 0, "R8");
    cyc(2, 2'b11, 0, 0, 0, 2'b00, 0, "R8");
    cyc(3, 2'b11, 0, 0, 0, 2'b00, 0, "R8");
    cyc(4, 2'b11, 0, 1, 0, 2'b00, 0, "R8");
    cyc(1, 2'b11, 0, 0, 1, 2'b00, 0, "R8");
    cyc(2, 2'b11, 0, 0, 1, 2'b00, 0, "R8");
    cyc(3, 2'b11, 0, 0, 1, 2'b00, 0, "R8");
    cyc(4, 2'b11, 0, 0, 1, 2'b00, 0, "R8");
    cyc(0, 2'b11, 0, 0, 1, 2'b00, 0, "R8");
    cyc(0, 2'b11, 0, 0, 0, 2'b01, 0, "R8");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b10, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    // R9 simultaneous requests
    cyc(0, 2'b00, 0, 0, 0, 2'b00, 0, "R9");
    cyc(0, 2'b11, 0, 0, 0, 2'b01, 0, "R9");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 1, "R9");
    cyc(0, 2'b10, 0, 0, 0, 2'b00, 1, "R9");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R9");
    cyc(0, 2'b11, 0, 0, 0, 2'b10, 0, "R9");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 1, "R9");
    cyc(0, 2'b01, 0, 0, 0, 2'b00, 1, "R9");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    // R10 request seen in T4 is early for next cycle
    cyc(1, 2'b11, 0, 0, 0, 2'b00, 0, "R10");
    cyc(2, 2'b11, 0, 0, 0, 2'b00, 0, "R10");
    cyc(3, 2'b11, 0, 0, 0, 2'b00, 0, "R10");
    cyc(4, 2'b01, 0, 0, 0, 2'b00, 0, "R10");
    cyc(1, 2'b11, 0, 0, 0, 2'b00, 0, "R10");
    cyc(2, 2'b11, 0, 0, 0, 2'b00, 0, "R10");
    cyc(3, 2'b11, 0, 0, 0, 2'b00, 0, "R10");
    cyc(4, 2'b11, 0, 0, 0, 2'b10, 0, "R10");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b01, 0, 0, 0, 2'b00, 1, "R3");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    cyc(0, 2'b11, 0, 0, 0, 2'b00, 0, "R5");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule